// File: doc/BRIEF.md
# Dual Look-Up Table Compensation Controller

This block turns a temperature reading into two output codes for a pair of current-output DACs. Every accepted ADC sample selects a row from its upper six bits. That row picks one byte from each of two 64-entry tables, and each byte drives its own DAC code port. Each channel also has a direction flag that selects whether its current generator sources or sinks. The second channel can instead take a fixed code from a register, which bypasses its table.

Software reaches the tables and the control registers through a write port and a combinational read port, both on a 9-bit byte address. The tables and a shadow copy of the control registers stand in for nonvolatile storage, so they keep their contents across reset. After every reset the working control registers reload from the shadow copy. The outputs stay forced off until that reload sequence has finished.

Top module: `lut_comp_ctrl`

## Requirements
- R1: While reset is asserted, and for RECALL_CYC (default 4) clock edges after it is released, `out_en` is 0. It rises on the RECALL_CYC-th edge after release and then stays at 1 until the next reset.
- R2: While `out_en` is 0, both DAC codes are 0 and both direction outputs are 0.
- R3: On the first edge after reset, the working registers at 80h, 81h and 84h are loaded from their stored copies. Every write to 80h also updates its stored copy.
- R4: Register 80h bit 3 is the persist bit. Writes to 81h and 84h always update the working register. They update the stored copy only when the persist bit is 1, so a write made with persist at 0 is lost at the next reset.
- R5: Table 1 is at byte addresses 90h–CFh and table 2 is at D0h–10Fh, where row = address minus the table base. Table entries can be read back, and they survive reset.
- R6: The row is ADC sample bits [7:2]. With register 80h bit 2 = 1 (filter off), every sample with `adc_vld` sets the row. `dac1_code` is then table 1 at that row. When 81h bit 0 is 0, `dac2_code` is table 2 at that row.
- R7: With register 80h bit 2 = 0 (filter on), a valid sample changes the row only if its row equals the row of the previous valid sample since reset.
- R8: With register 81h bit 0 = 1, `dac2_code` is the 8-bit value of register 84h, and `dac1_code` still follows table 1.
- R9: Register 80h bit 0 drives `dir1` and bit 1 drives `dir2`. A value of 0 means source and 1 means sink.
- R10: Address 87h reads the most recent valid ADC sample. Writes to 87h have no effect.
- R11: Addresses 88h–8Fh read as 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| adc_data | input | ADC_W | Temperature sample |
| adc_vld | input | 1 | Sample strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 9 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 9 | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| dac1_code | output | 8 | Channel 1 DAC code |
| dac2_code | output | 8 | Channel 2 DAC code |
| dir1 | output | 1 | Channel 1 direction (1 = sink) |
| dir2 | output | 1 | Channel 2 direction (1 = sink) |
| out_en | output | 1 | Outputs enabled after recall |

## Verification
The hardest case to reach is a stored copy that differs from its working register. This requires writes made with the persist bit cleared, followed by a reset, and then a comparison of the values that come back. The bench stores a direct code while persist is set, clears persist, and overwrites the working value. It then resets and checks the reloaded code both at the read port and at `dac2_code`. The filter's pairing rule needs sample sequences whose row differs from the previous sample while the low two bits vary. These sequences show that only the upper bits are compared.

// File: rtl/lutc_pkg.sv
`timescale 1ns/1ps
package lutc_pkg;
    localparam int ADDR_W = 9;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL0  = 9'h080;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 9'h081;
    localparam logic [ADDR_W-1:0] ADR_CODE2  = 9'h084;
    localparam logic [ADDR_W-1:0] ADR_ADC    = 9'h087;
    localparam logic [ADDR_W-1:0] ADR_RSV_LO = 9'h088;
    localparam logic [ADDR_W-1:0] ADR_RSV_HI = 9'h08F;
    localparam logic [ADDR_W-1:0] ADR_TBL1   = 9'h090;

    // control register 0, bit 0 upward: sink1, sink2, filt_off, persist
    typedef struct packed {
        logic persist;
        logic filt_off;
        logic sink2;
        logic sink1;
    } ctrl0_t;

    localparam int CTRL0_W = $bits(ctrl0_t);
endpackage

// File: rtl/lutc_recall.sv
`timescale 1ns/1ps
module lutc_recall #(
    parameter int RECALL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic load,
    output logic done
);
    localparam int CNT_W = $clog2(RECALL_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(RECALL_CYC - 1)) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load = !st_q.done && (st_q.cnt == '0);
    assign done = st_q.done;

    a_r1_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    a_r1_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/lutc_row_filter.sv
`timescale 1ns/1ps
module lutc_row_filter #(
    parameter int SMP_W = 8,
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    input  logic             filt_off,
    output logic [ROW_W-1:0] row
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] cand;
        logic             cand_ok;
    } st_t;

    st_t st_d, st_q;
    logic [ROW_W-1:0] new_row;

    assign new_row = smp[SMP_W-1 -: ROW_W];

    always_comb begin
        st_d = st_q;
        if (smp_vld) begin
            st_d.cand    = new_row;
            st_d.cand_ok = 1'b1;
            if (filt_off || (st_q.cand_ok && st_q.cand == new_row))
                st_d.row = new_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row = st_q.row;

    a_r7_row_moves_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.row) |-> $past(smp_vld));
    a_r7_filtered_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.row) && !$past(filt_off)) |-> ($past(st_q.cand) == st_q.row));
endmodule

// File: rtl/lutc_store.sv
`timescale 1ns/1ps
module lutc_store import lutc_pkg::*; #(
    parameter int ROW_W = 6
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               persist,
    input  logic [ROW_W-1:0]   row,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  lut1,
    output logic [BYTE_W-1:0]  lut2,
    output logic [BYTE_W-1:0]  rd_tbl,
    output logic [CTRL0_W-1:0] sh_ctrl0,
    output logic               sh_mode,
    output logic [BYTE_W-1:0]  sh_code2
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int TBL_N = 2 * DEPTH;
    localparam int IDX_W = ROW_W + 1;

    typedef struct packed {
        logic [TBL_N-1:0][BYTE_W-1:0] tbl;
        logic [CTRL0_W-1:0]           c0;
        logic                         mode;
        logic [BYTE_W-1:0]            code2;
    } mem_t;

    mem_t mem_d, mem_q;
    logic [ADDR_W-1:0] woff, roff;

    assign woff = wr_addr - ADR_TBL1;
    assign roff = rd_addr - ADR_TBL1;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            if (woff < ADDR_W'(TBL_N)) mem_d.tbl[woff[IDX_W-1:0]] = wr_data;
            case (wr_addr)
                ADR_CTRL0: mem_d.c0 = wr_data[CTRL0_W-1:0];
                ADR_MODE:  if (persist) mem_d.mode  = wr_data[0];
                ADR_CODE2: if (persist) mem_d.code2 = wr_data;
                default: ;
            endcase
        end
    end

    // stored contents model nonvolatile cells: no reset
    always_ff @(posedge clk) mem_q <= mem_d;

    assign lut1     = mem_q.tbl[{1'b0, row}];
    assign lut2     = mem_q.tbl[{1'b1, row}];
    assign rd_tbl   = (roff < ADDR_W'(TBL_N)) ? mem_q.tbl[roff[IDX_W-1:0]] : '0;
    assign sh_ctrl0 = mem_q.c0;
    assign sh_mode  = mem_q.mode;
    assign sh_code2 = mem_q.code2;
endmodule

// File: rtl/lut_comp_ctrl.sv
`timescale 1ns/1ps
module lut_comp_ctrl import lutc_pkg::*; #(
    parameter int ADC_W      = 8,
    parameter int ROW_W      = 6,
    parameter int RECALL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              adc_vld,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] dac1_code,
    output logic [BYTE_W-1:0] dac2_code,
    output logic              dir1,
    output logic              dir2,
    output logic              out_en
);
    typedef struct packed {
        ctrl0_t            c0;
        logic              mode;
        logic [BYTE_W-1:0] code2;
        logic [ADC_W-1:0]  adc;
    } st_t;

    st_t st_d, st_q;

    logic               load, done;
    logic [ROW_W-1:0]   row;
    logic [BYTE_W-1:0]  lut1, lut2, rd_tbl, sh_code2;
    logic [CTRL0_W-1:0] sh_ctrl0;
    logic               sh_mode;

    lutc_recall #(.RECALL_CYC(RECALL_CYC)) u_recall (
        .clk(clk), .rst_n(rst_n), .load(load), .done(done)
    );

    lutc_row_filter #(.SMP_W(ADC_W), .ROW_W(ROW_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .smp_vld(adc_vld), .smp(adc_data),
        .filt_off(st_q.c0.filt_off), .row(row)
    );

    lutc_store #(.ROW_W(ROW_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .persist(st_q.c0.persist), .row(row), .rd_addr(rd_addr),
        .lut1(lut1), .lut2(lut2), .rd_tbl(rd_tbl),
        .sh_ctrl0(sh_ctrl0), .sh_mode(sh_mode), .sh_code2(sh_code2)
    );

    always_comb begin
        st_d = st_q;
        if (adc_vld) st_d.adc = adc_data;
        if (load) begin
            st_d.c0    = ctrl0_t'(sh_ctrl0);
            st_d.mode  = sh_mode;
            st_d.code2 = sh_code2;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL0: st_d.c0    = ctrl0_t'(wr_data[CTRL0_W-1:0]);
                ADR_MODE:  st_d.mode  = wr_data[0];
                ADR_CODE2: st_d.code2 = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            ADR_CTRL0: rd_data = BYTE_W'(st_q.c0);
            ADR_MODE:  rd_data = BYTE_W'(st_q.mode);
            ADR_CODE2: rd_data = st_q.code2;
            ADR_ADC:   rd_data = BYTE_W'(st_q.adc);
            default:   rd_data = rd_tbl;
        endcase
    end

    assign out_en    = done;
    assign dac1_code = done ? lut1 : '0;
    assign dac2_code = done ? (st_q.mode ? st_q.code2 : lut2) : '0;
    assign dir1      = done && st_q.c0.sink1;
    assign dir2      = done && st_q.c0.sink2;

    a_r2_quiet_until_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (dac1_code == '0 && dac2_code == '0 && !dir1 && !dir2));
    a_r3_recall_loads_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && $past(rst_n)) |->
            (st_q.code2 == $past(sh_code2) && st_q.mode == $past(sh_mode)));
    a_r4_volatile_write_spares_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CODE2 && !st_q.c0.persist) |=> $stable(sh_code2));
    a_r11_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADR_RSV_LO && rd_addr <= ADR_RSV_HI) |-> rd_data == '0);
endmodule

// File: tb/lut_comp_ctrl_test.sv
`timescale 1ns/1ps
module lut_comp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] adc_data = '0;
    logic       adc_vld = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data, dac1_code, dac2_code;
    logic       dir1, dir2, out_en;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lut_comp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_vld(adc_vld),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .dac1_code(dac1_code), .dac2_code(dac2_code),
        .dir1(dir1), .dir2(dir2), .out_en(out_en)
    );

    function automatic int t1v(int i); return (i * 3 + 1) & 255; endfunction
    function automatic int t2v(int i); return 255 - i; endfunction

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        rd_addr = 9'(a);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic smp(int v);
        @(negedge clk);
        adc_vld = 1'b1; adc_data = 8'(v);
        @(negedge clk);
        adc_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 en in reset", int'(out_en), 0);
        chk("R2 codes in reset", int'({dac1_code, dac2_code, dir1, dir2}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 en during recall", int'(out_en), 0);
        chk("R2 dac1 during recall", int'(dac1_code), 0);
        chk("R2 dirs during recall", int'({dir1, dir2}), 0);
        @(negedge clk);
        chk("R1 en after recall", int'(out_en), 1);
    endtask

    task automatic t_program();
        wr('h80, 'h0C);
        for (int i = 0; i < 64; i++) begin
            wr('h90 + i, t1v(i));
            wr('hD0 + i, t2v(i));
        end
        wr('h81, 0);
        wr('h84, 0);
        rd_chk("R5 tbl1 first", 'h90, t1v(0));
        rd_chk("R5 tbl1 last", 'hCF, t1v(63));
        rd_chk("R5 tbl2 first", 'hD0, t2v(0));
        rd_chk("R5 tbl2 last", 'h10F, t2v(63));
    endtask

    task automatic t_lookup();
        int vals[4] = '{'h00, 'h17, 'hFC, 'h80};
        foreach (vals[k]) begin
            smp(vals[k]);
            chk("R6 dac1 lookup", int'(dac1_code), t1v(vals[k] >> 2));
            chk("R6 dac2 lookup", int'(dac2_code), t2v(vals[k] >> 2));
            rd_chk("R10 adc readback", 'h87, vals[k]);
        end
    endtask

    task automatic t_filter();
        wr('h80, 'h08);
        smp('h40); chk("R7 single sample held", int'(dac1_code), t1v(32));
        smp('h41); chk("R7 pair accepted", int'(dac1_code), t1v(16));
        smp('h90); chk("R7 new row held", int'(dac1_code), t1v(16));
        smp('h44); chk("R7 differing pair held", int'(dac1_code), t1v(16));
        smp('h45); chk("R7 second pair accepted", int'(dac1_code), t1v(17));
        chk("R7 dac2 follows row", int'(dac2_code), t2v(17));
    endtask

    task automatic t_direct();
        wr('h84, 'h3C);
        wr('h81, 1);
        chk("R8 dac2 direct", int'(dac2_code), 'h3C);
        chk("R8 dac1 still table", int'(dac1_code), t1v(17));
        wr('h80, 'h09);
        chk("R9 dir1 sink", int'(dir1), 1);
        chk("R9 dir2 source", int'(dir2), 0);
        wr('h80, 'h0A);
        chk("R9 dir1 source", int'(dir1), 0);
        chk("R9 dir2 sink", int'(dir2), 1);
    endtask

    task automatic t_reserved();
        wr('h8A, 'hFF);
        rd_chk("R11 reserved 8A", 'h8A, 0);
        rd_chk("R11 reserved 88", 'h88, 0);
        rd_chk("R11 ctrl0 untouched", 'h80, 'h0A);
        chk("R11 dac1 untouched", int'(dac1_code), t1v(17));
        wr('h87, 'h11);
        rd_chk("R10 adc write ignored", 'h87, 'h45);
    endtask

    task automatic t_persist();
        wr('h80, 'h02);
        wr('h84, 'h77);
        rd_chk("R4 volatile write visible", 'h84, 'h77);
        chk("R4 dac2 volatile code", int'(dac2_code), 'h77);
        do_reset();
        rd_chk("R4 code2 recalled", 'h84, 'h3C);
        rd_chk("R3 mode recalled", 'h81, 1);
        rd_chk("R3 ctrl0 recalled", 'h80, 'h02);
        chk("R3 dac2 after recall", int'(dac2_code), 'h3C);
        chk("R3 dirs after recall", int'({dir1, dir2}), 1);
        chk("R5 dac1 row0 after reset", int'(dac1_code), t1v(0));
        rd_chk("R5 tbl1 survives", 'h95, t1v(5));
        rd_chk("R5 tbl2 survives", 'h10F, t2v(63));
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_program();
        t_lookup();
        t_filter();
        t_direct();
        t_reserved();
        t_persist();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule